// File: doc/BRIEF.md
# Fixed-Address Single-Channel DMA Engine

This block is one DMA channel that copies a single byte or a single 16-bit word each time a peripheral asks for it. The two endpoints never move. One is a full memory address. The other is a short I/O address whose missing upper bits are forced to all ones, so it always lands in the top window of the address space. A direction bit chooses which endpoint is read and which is written. A transfer counter limits the number of copies. When the counter expires, the channel disables itself and can raise an interrupt.

Software programs four registers through a simple write/select port:

| Select | Register | Contents |
|--------|----------|----------|
| 0 | Control | bit0 enable, bit1 direction, bit2 interrupt enable, bit3 write-one-to-clear the interrupt. On read, bit3 returns the interrupt state. |
| 1 | Memory address | The memory-side endpoint. |
| 2 | I/O address | The I/O-side endpoint. |
| 3 | Count | The remaining transfer count. |

The peripheral drives `dreq`, and `xfer_word` gives the size of the access. Each transfer runs on the bus master port as one read followed by one write. Each access is held until `bus_rdy` is seen high at a clock edge.

Top module: `fadma_chan`

## Requirements
- R1: A request accepted while the channel is enabled and idle produces exactly one bus read followed by exactly one bus write. `bus_word` equals the `xfer_word` value sampled when the request was accepted.
- R2: Transfers never change the memory-address or I/O-address registers. Every transfer of a run uses the same two addresses.
- R3: The I/O-side bus address is the 16-bit I/O register with every bit above bit 15 set to one.
- R4: With direction 0, the read goes to the memory address and the write goes to the I/O address. With direction 1, the roles are swapped.
- R5: The count register drops by exactly one when each bus write completes.
- R6: When a completed write takes the count from 1 to 0, the enable bit clears and later requests cause no bus activity.
- R7: At that expiry, the interrupt output rises if the interrupt enable bit (control bit2) is 1. It stays low if that bit is 0.
- R8: A count loaded as 0 gives 2^CNT_W transfers before the channel disables itself.
- R9: A request is ignored, with no queuing, if it arrives while the enable bit is 0 or while a transfer is in progress.
- R10: The interrupt output is low after reset. It stays high until a control write has bit3 or bit0 set.
- R11: A word transfer writes the 16 bits that were read. A byte transfer writes the low byte that was read, with bits 15:8 of `bus_wdata` at zero.
- R12: While `bus_rdy` is low, the bus request, address and write strobe stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 memory address, 2 I/O address, 3 count) |
| cfg_wdata | input | MEM_AW | Register write data |
| cfg_rdata | output | MEM_AW | Readback of the selected register |
| dreq | input | 1 | Transfer request from the peripheral |
| xfer_word | input | 1 | 1 selects a word transfer, 0 selects a byte transfer |
| bus_req | output | 1 | Bus access active |
| bus_we | output | 1 | 1 for a write access, 0 for a read access |
| bus_word | output | 1 | Size of the current access |
| bus_addr | output | MEM_AW | Access address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, captured when `bus_rdy` is high |
| bus_rdy | input | 1 | Access completes at a clock edge where this is high |
| irq | output | 1 | Transfer-end interrupt request |

## Verification
The bench keeps the 24-bit memory address and the 16-bit I/O address at their default widths, so the forced-ones upper byte and the direction swap are seen on real addresses. It builds the block with CNT_W set to 4. That makes a zero count mean 16 transfers, so the full wrap-around run from zero to expiry fits in the run and is counted write by write. The bus model inserts zero to two wait states, which exercises the access hold and the rejection of requests that arrive mid-transfer.

// File: rtl/fadma_pkg.sv
package fadma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_st_e;

  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_MEM  = 2'd1;
  localparam logic [1:0] RSEL_IO   = 2'd2;
  localparam logic [1:0] RSEL_CNT  = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_IE   = 2;
  localparam int CB_ICLR = 3;
endpackage

// File: rtl/fadma_regs.sv
module fadma_regs
  import fadma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MEM_AW-1:0] cfg_wdata,
  input  logic              xfer_done,
  output logic [MEM_AW-1:0] cfg_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [IO_AW-1:0]  io_addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              dir,
  output logic              ie,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [MEM_AW-1:0] mem_q, mem_n;
  logic [IO_AW-1:0]  io_q, io_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              en_q, en_n, dir_q, dir_n, ie_q, ie_n, irq_q, irq_n;

  always_comb begin
    mem_n = mem_q;
    io_n  = io_q;
    cnt_n = cnt_q;
    en_n  = en_q;
    dir_n = dir_q;
    ie_n  = ie_q;
    irq_n = irq_q;
    if (xfer_done) begin
      cnt_n = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        en_n = 1'b0;
        if (ie_q) irq_n = 1'b1;
      end
    end
    if (cfg_we) begin
      case (cfg_sel)
        RSEL_CTRL: begin
          en_n  = cfg_wdata[CB_EN];
          dir_n = cfg_wdata[CB_DIR];
          ie_n  = cfg_wdata[CB_IE];
          if (cfg_wdata[CB_ICLR] || cfg_wdata[CB_EN]) irq_n = 1'b0;
        end
        RSEL_MEM: mem_n = cfg_wdata;
        RSEL_IO:  io_n  = cfg_wdata[IO_AW-1:0];
        default:  cnt_n = cfg_wdata[CNT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      io_q  <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      mem_q <= mem_n;
      io_q  <= io_n;
      cnt_q <= cnt_n;
      en_q  <= en_n;
      dir_q <= dir_n;
      ie_q  <= ie_n;
      irq_q <= irq_n;
    end
  end

  always_comb begin
    case (cfg_sel)
      RSEL_CTRL: cfg_rdata = MEM_AW'({irq_q, ie_q, dir_q, en_q});
      RSEL_MEM:  cfg_rdata = mem_q;
      RSEL_IO:   cfg_rdata = MEM_AW'(io_q);
      default:   cfg_rdata = MEM_AW'(cnt_q);
    endcase
  end

  assign mem_addr = mem_q;
  assign io_addr  = io_q;
  assign cnt      = cnt_q;
  assign en       = en_q;
  assign dir      = dir_q;
  assign ie       = ie_q;
  assign irq      = irq_q;
endmodule

// File: rtl/fadma_addr.sv
module fadma_addr #(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16
) (
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              dir,
  output logic [MEM_AW-1:0] src_addr,
  output logic [MEM_AW-1:0] dst_addr
);
  localparam int PAD_W = MEM_AW - IO_AW;

  logic [MEM_AW-1:0] io_full;

  generate
    if (PAD_W > 0) begin : g_pad
      assign io_full = {{PAD_W{1'b1}}, io_addr};
    end else begin : g_nopad
      assign io_full = io_addr[MEM_AW-1:0];
    end
  endgenerate

  assign src_addr = dir ? io_full : mem_addr;
  assign dst_addr = dir ? mem_addr : io_full;
endmodule

// File: rtl/fadma_xfer.sv
module fadma_xfer
  import fadma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dreq,
  input  logic              en,
  input  logic              word_in,
  input  logic [MEM_AW-1:0] src_addr,
  input  logic [MEM_AW-1:0] dst_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              xfer_done
);
  localparam int BYTE_W = 8;

  xfer_st_e          st_q, st_n;
  logic              word_q, word_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              take, latch;

  assign take  = (st_q == ST_IDLE) && dreq && en;
  assign latch = (st_q == ST_READ) && bus_rdy;

  always_comb begin
    st_n   = st_q;
    word_n = word_q;
    data_n = data_q;
    if (take)  word_n = word_in;
    if (latch) data_n = bus_rdata;
    case (st_q)
      ST_IDLE:  if (take)    st_n = ST_READ;
      ST_READ:  if (bus_rdy) st_n = ST_WRITE;
      ST_WRITE: if (bus_rdy) st_n = ST_IDLE;
      default:               st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      word_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_n;
      word_q <= word_n;
      data_q <= data_n;
    end
  end

  assign bus_req   = (st_q != ST_IDLE);
  assign bus_we    = (st_q == ST_WRITE);
  assign bus_word  = word_q;
  assign bus_addr  = bus_we ? dst_addr : src_addr;
  assign bus_wdata = word_q ? data_q : DATA_W'(data_q[BYTE_W-1:0]);
  assign xfer_done = (st_q == ST_WRITE) && bus_rdy;
endmodule

// File: rtl/fadma_chan.sv
module fadma_chan #(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MEM_AW-1:0] cfg_wdata,
  output logic [MEM_AW-1:0] cfg_rdata,
  input  logic              dreq,
  input  logic              xfer_word,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy,
  output logic              irq
);
  logic [MEM_AW-1:0] mem_addr, src_addr, dst_addr;
  logic [IO_AW-1:0]  io_addr;
  logic [CNT_W-1:0]  ch_cnt;
  logic              ch_en, ch_dir, ch_ie, xfer_done;

  fadma_regs #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_done(xfer_done), .cfg_rdata(cfg_rdata),
    .mem_addr(mem_addr), .io_addr(io_addr), .cnt(ch_cnt), .en(ch_en),
    .dir(ch_dir), .ie(ch_ie), .irq(irq)
  );

  fadma_addr #(.MEM_AW(MEM_AW), .IO_AW(IO_AW)) u_addr (
    .mem_addr(mem_addr), .io_addr(io_addr), .dir(ch_dir),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  fadma_xfer #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .en(ch_en), .word_in(xfer_word),
    .src_addr(src_addr), .dst_addr(dst_addr), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .xfer_done(xfer_done)
  );
endmodule

// File: rtl/fadma_chan_chk.sv
module fadma_chan_chk #(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_rdy,
  input logic [MEM_AW-1:0] bus_addr,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [CNT_W-1:0]  ch_cnt,
  input logic              ch_en,
  input logic              ch_dir,
  input logic              ch_ie,
  input logic              irq
);
  logic wr_end;
  assign wr_end = bus_req && bus_we && bus_rdy && !cfg_we;

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_we); // R1
  AST_MEM_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_we == ch_dir) |-> bus_addr == mem_addr); // R4
  AST_IO_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_we != ch_dir) |-> &bus_addr[MEM_AW-1:IO_AW]); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> ch_cnt == $past(ch_cnt) - CNT_W'(1)); // R5
  AST_END_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end && ch_cnt == CNT_W'(1) |=> !ch_en); // R6
  AST_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end && ch_cnt == CNT_W'(1) && ch_ie |=> irq); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_we |=> irq); // R10
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && !ch_en |=> !bus_req); // R9
  AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy && !cfg_we |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R12
endmodule

bind fadma_chan fadma_chan_chk #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bus_req(bus_req), .bus_we(bus_we),
  .bus_rdy(bus_rdy), .bus_addr(bus_addr), .mem_addr(mem_addr), .ch_cnt(ch_cnt),
  .ch_en(ch_en), .ch_dir(ch_dir), .ch_ie(ch_ie), .irq(irq)
);

// File: tb/tb_fadma_chan.sv
`timescale 1ns/1ps
module tb_fadma_chan;
  localparam int MEM_AW = 24;
  localparam int IO_AW  = 16;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [MEM_AW-1:0] cfg_wdata = '0;
  logic [MEM_AW-1:0] cfg_rdata;
  logic              dreq = 1'b0;
  logic              xfer_word = 1'b1;
  logic              bus_req, bus_we, bus_word;
  logic [MEM_AW-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              bus_rdy = 1'b0;
  logic              irq;

  always #4 clk = ~clk;

  fadma_chan #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
    .xfer_word(xfer_word), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .irq(irq)
  );

  function automatic logic [15:0] mem_val(input logic [MEM_AW-1:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  typedef struct {
    logic [MEM_AW-1:0] rd_a;
    logic [MEM_AW-1:0] wr_a;
    logic [15:0]       wr_d;
    logic              word;
  } exp_t;
  exp_t exp_q[$];

  int vectors = 0;
  int errs = 0;
  int n_wr = 0;
  int lat = 0;
  int wait_ctr = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus model with monitor: completion recorded when ready is granted
  always @(negedge clk) begin
    if (bus_rdy) begin
      bus_rdy <= 1'b0;
      wait_ctr <= 0;
    end else if (bus_req) begin
      if (wait_ctr >= lat) begin
        bus_rdy <= 1'b1;
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected bus access", bus_addr, 0);
        end else if (!bus_we) begin
          check(bus_addr == exp_q[0].rd_a, "R2/R4 read address", bus_addr, exp_q[0].rd_a);
          check(bus_word == exp_q[0].word, "R1 size", bus_word, exp_q[0].word);
        end else begin
          n_wr++;
          check(bus_addr == exp_q[0].wr_a, "R3/R4 write address", bus_addr, exp_q[0].wr_a);
          check(bus_wdata == exp_q[0].wr_d, "R11 write data", bus_wdata, exp_q[0].wr_d);
          void'(exp_q.pop_front());
        end
      end else begin
        wait_ctr <= wait_ctr + 1;
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [MEM_AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, output logic [MEM_AW-1:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic push_exp(input logic [MEM_AW-1:0] s, input logic [MEM_AW-1:0] t, input logic w);
    exp_t e;
    e.rd_a = s; e.wr_a = t; e.word = w;
    e.wr_d = w ? mem_val(s) : {8'h00, mem_val(s)[7:0]};
    exp_q.push_back(e);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
  endtask

  task automatic do_xfer(input logic [MEM_AW-1:0] s, input logic [MEM_AW-1:0] t, input logic w);
    xfer_word = w;
    push_exp(s, t, w);
    pulse_req();
    repeat (12) @(negedge clk);
  endtask

  localparam logic [MEM_AW-1:0] MEMA = 24'h123456;
  localparam logic [MEM_AW-1:0] IOF  = 24'hFF0ABC;

  initial begin
    logic [MEM_AW-1:0] rd;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    cfg_rd(2'd0, rd);
    check(rd == 0, "R10 reset control/irq", rd, 0);
    check(irq == 0 && bus_req == 0, "R10 reset outputs", {irq, bus_req}, 0);

    // direction 0, word, count 3, interrupt enabled
    cfg_wr(2'd1, MEMA);
    cfg_wr(2'd2, 24'h000ABC);
    cfg_wr(2'd3, 24'd3);
    cfg_wr(2'd0, 24'h5);
    lat = 1;
    do_xfer(MEMA, IOF, 1'b1);
    do_xfer(MEMA, IOF, 1'b1);
    cfg_rd(2'd3, rd);
    check(rd == 1, "R5 count after two", rd, 1);
    cfg_rd(2'd0, rd);
    check(rd[0] == 1 && irq == 0, "R6 still enabled before end", {rd[0], irq}, 2);
    do_xfer(MEMA, IOF, 1'b1);
    cfg_rd(2'd3, rd);
    check(rd == 0, "R5 count at end", rd, 0);
    cfg_rd(2'd0, rd);
    check(rd[0] == 0, "R6 enable cleared", rd[0], 0);
    check(irq == 1, "R7 irq raised", irq, 1);
    base = n_wr;
    pulse_req();
    repeat (12) @(negedge clk);
    check(n_wr == base, "R6 no transfer after end", n_wr, base);
    check(irq == 1, "R10 irq held", irq, 1);
    cfg_rd(2'd1, rd);
    check(rd == MEMA, "R2 memory address unchanged", rd, MEMA);
    cfg_rd(2'd2, rd);
    check(rd == 24'h000ABC, "R2 io address unchanged", rd, 24'h000ABC);
    cfg_wr(2'd0, 24'h8);
    #1 check(irq == 0, "R10 irq cleared by bit3", irq, 0);

    // direction 1, byte, count 2, interrupt disabled, no wait states
    lat = 0;
    cfg_wr(2'd3, 24'd2);
    cfg_wr(2'd0, 24'h3);
    do_xfer(IOF, MEMA, 1'b0);
    do_xfer(IOF, MEMA, 1'b0);
    cfg_rd(2'd0, rd);
    check(rd[0] == 0 && irq == 0, "R7 no irq when disabled", {rd[0], irq}, 0);

    // request while disabled
    base = n_wr;
    pulse_req();
    repeat (12) @(negedge clk);
    check(n_wr == base, "R9 ignored while disabled", n_wr, base);

    // request while busy
    lat = 2;
    cfg_wr(2'd3, 24'd5);
    cfg_wr(2'd0, 24'h1);
    xfer_word = 1'b1;
    push_exp(MEMA, IOF, 1'b1);
    pulse_req();
    pulse_req();
    repeat (14) @(negedge clk);
    cfg_rd(2'd3, rd);
    check(rd == 4, "R9 busy request ignored", rd, 4);
    check(exp_q.size() == 0, "R1 one write per request", exp_q.size(), 0);

    // zero count gives 2^CNT_W transfers
    lat = 0;
    cfg_wr(2'd3, 24'd0);
    cfg_wr(2'd0, 24'h5);
    base = n_wr;
    for (int i = 0; i < (1 << CNT_W); i++) begin
      do_xfer(MEMA, IOF, 1'b1);
    end
    check(n_wr - base == (1 << CNT_W), "R8 full-range count", n_wr - base, 1 << CNT_W);
    cfg_rd(2'd0, rd);
    check(rd[0] == 0 && irq == 1, "R8 end after full range", {rd[0], irq}, 1);
    cfg_wr(2'd0, 24'h1);
    #1 check(irq == 0, "R10 irq cleared by enable write", irq, 0);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      errs++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule